// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block forms the 16-bit data-memory address for each operand access of a signal-processing core. It works in one of two ways. In direct mode, a 9-bit page register sits in the upper address bits and the 7-bit offset from the instruction fills the lower bits. This divides data memory into 512 pages of 128 words. In indirect mode, the address is the current value of one of eight 16-bit address registers. A 3-bit selector register picks which one.

After an indirect access, the selected register can be stepped in one of seven ways: held, incremented, decremented, or moved forward or back by the contents of register 0, which acts as the index. The forward and backward index moves each come in two forms, a normal one and a bit-reversed one. The bit-reversed step carries from the MSB toward the LSB, so it walks the scrambled sample order of a radix-2 FFT. Whenever a new selector value is loaded, a history register keeps the value it replaces.

Instruction decode and the memories lie outside the block. It receives a step code, load controls for the page, the selector and the registers, and an optional new selector value.

Top module: `agu_top`

## Requirements
- R1: While rst_ni is low, all eight address registers, the page register, the selector and the history register are zero.
- R2: With indirect_i low, addr_o equals {page register, offset_i}: the page sits in bits 15:7 and the offset in bits 6:0. An access in this mode changes no address register, whatever mode_i holds.
- R3: With indirect_i high, addr_o is the value of the register chosen by the selector before any update. The update from an access with access_i high is visible from the next cycle on.
- R4: Step codes 0, 1 and 2 hold, increment and decrement the selected register. Increment and decrement wrap modulo 2^16, and code 7 behaves as hold.
- R5: Step codes 3 and 4 add and subtract register 0 from the selected register, modulo 2^16.
- R6: Step codes 5 and 6 add and subtract register 0 with the carry or borrow travelling from the MSB toward the LSB. With register 0 = 8, code 5 walks 0, 8, 4, 12, 2; code 6 from 2 gives 12; code 6 from 0 gives 15.
- R7: A selector load (ptr_ld_i) takes effect in the next cycle. A step in the same cycle applies to the register chosen by the old selector, and the history register receives the old selector value.
- R8: A direct write (ar_wr_i) to a register overrides a step aimed at the same register in the same cycle. Without ptr_ld_i, the selector and the history register hold their values.
- R9: page_ld_i loads page_i into the page register, which is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| indirect_i | input | 1 | 1 selects register addressing, 0 page/offset addressing |
| access_i | input | 1 | An operand access happens this cycle |
| offset_i | input | 7 | Offset field from the instruction |
| mode_i | input | 3 | Step code applied after an indirect access |
| ptr_ld_i | input | 1 | Load a new selector value |
| ptr_i | input | 3 | New selector value |
| page_ld_i | input | 1 | Load the page register |
| page_i | input | 9 | New page value |
| ar_wr_i | input | 1 | Write an address register |
| ar_wr_sel_i | input | 3 | Register to write |
| ar_wr_data_i | input | 16 | Value to write |
| addr_o | output | 16 | Data-memory address |
| ptr_o | output | 3 | Current selector |
| prev_ptr_o | output | 3 | Selector value before the last load |

## Verification
addr_o is combinational from the current state and the inputs, so it is due in the same cycle that a stimulus is applied. Register steps, selector loads, page loads and writes change the state at the next rising edge, so they show one cycle later. The bench drives inputs just after a falling edge and samples 1 ns later, before the rising edge that commits the update. Every step result is therefore read as the address of the following access. The address sequences in the vector table are calculated by hand from the requirements, including the wraps and the reversed-carry FFT walk.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    STEP_HOLD = 3'd0,
    STEP_INC  = 3'd1,
    STEP_DEC  = 3'd2,
    STEP_ADD  = 3'd3,
    STEP_SUB  = 3'd4,
    STEP_RADD = 3'd5,
    STEP_RSUB = 3'd6,
    STEP_RSVD = 3'd7
  } step_e;
endpackage

// File: rtl/agu_rev_step.sv
// a +/- b with the carry chain running MSB -> LSB
module agu_rev_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] a_r, b_r, s_r;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_r[i]     = a_i[W-1-i];
    assign b_r[i]     = b_i[W-1-i];
    assign y_o[W-1-i] = s_r[i];
  end

  assign s_r = sub_i ? (a_r - b_r) : (a_r + b_r);
endmodule

// File: rtl/agu_ptr_ctrl.sv
module agu_ptr_ctrl #(
  parameter int PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [PW-1:0] ptr_i,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] prev_o
);
  logic [PW-1:0] ptr_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      prev_q <= '0;
    end else if (ld_i) begin
      prev_q <= ptr_q;
      ptr_q  <= ptr_i;
    end
  end

  assign ptr_o  = ptr_q;
  assign prev_o = prev_q;

  p_hist_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (prev_q == $past(ptr_q)) && (ptr_q == $past(ptr_i)));

  p_ptr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(ptr_q) && $stable(prev_q));
endmodule

// File: rtl/agu_ar_file.sv
module agu_ar_file
  import agu_pkg::*;
#(
  parameter int AW  = 16,
  parameter int NAR = 8,
  localparam int PW = $clog2(NAR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [2:0]    mode_i,
  input  logic [PW-1:0] sel_i,
  input  logic          wr_i,
  input  logic [PW-1:0] wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  output logic [AW-1:0] rd_o
);
  logic [NAR-1:0][AW-1:0] ar_q;
  logic [AW-1:0] cur, idx, nxt, rev_y;
  step_e step;

  assign step = step_e'(mode_i);
  assign cur  = ar_q[sel_i];
  assign idx  = ar_q[0];
  assign rd_o = cur;

  agu_rev_step #(.W(AW)) u_rev (
    .a_i  (cur),
    .b_i  (idx),
    .sub_i(step == STEP_RSUB),
    .y_o  (rev_y)
  );

  always_comb begin
    unique case (step)
      STEP_INC:             nxt = cur + AW'(1);
      STEP_DEC:             nxt = cur - AW'(1);
      STEP_ADD:             nxt = cur + idx;
      STEP_SUB:             nxt = cur - idx;
      STEP_RADD, STEP_RSUB: nxt = rev_y;
      default:              nxt = cur;
    endcase
  end

  for (genvar r = 0; r < NAR; r++) begin : g_ar
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ar_q[r] <= '0;
      else if (wr_i && wr_sel_i == PW'(r))     ar_q[r] <= wr_data_i;
      else if (upd_i && sel_i == PW'(r))       ar_q[r] <= nxt;
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !wr_i) |=> $stable(ar_q));

  p_wr_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ar_q[$past(wr_sel_i)] == $past(wr_data_i));

  p_inc_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && step == STEP_INC && !(wr_i && wr_sel_i == sel_i))
      |=> ar_q[$past(sel_i)] == AW'($past(rd_o) + AW'(1)));

  p_add_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && step == STEP_ADD && sel_i != '0 && !wr_i)
      |=> ar_q[$past(sel_i)] == AW'($past(rd_o) + $past(ar_q[0])));
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int AW  = 16,
  parameter int PGW = 9,
  parameter int NAR = 8,
  localparam int OFW = AW - PGW,
  localparam int PW  = $clog2(NAR)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           indirect_i,
  input  logic           access_i,
  input  logic [OFW-1:0] offset_i,
  input  logic [2:0]     mode_i,
  input  logic           ptr_ld_i,
  input  logic [PW-1:0]  ptr_i,
  input  logic           page_ld_i,
  input  logic [PGW-1:0] page_i,
  input  logic           ar_wr_i,
  input  logic [PW-1:0]  ar_wr_sel_i,
  input  logic [AW-1:0]  ar_wr_data_i,
  output logic [AW-1:0]  addr_o,
  output logic [PW-1:0]  ptr_o,
  output logic [PW-1:0]  prev_ptr_o
);
  logic [PGW-1:0] page_q;
  logic [AW-1:0]  ar_rd;
  logic [PW-1:0]  sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        page_q <= '0;
    else if (page_ld_i) page_q <= page_i;
  end

  agu_ptr_ctrl #(.PW(PW)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ptr_ld_i),
    .ptr_i (ptr_i),
    .ptr_o (sel),
    .prev_o(prev_ptr_o)
  );

  agu_ar_file #(.AW(AW), .NAR(NAR)) u_ar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (access_i & indirect_i),
    .mode_i   (mode_i),
    .sel_i    (sel),
    .wr_i     (ar_wr_i),
    .wr_sel_i (ar_wr_sel_i),
    .wr_data_i(ar_wr_data_i),
    .rd_o     (ar_rd)
  );

  assign ptr_o  = sel;
  assign addr_o = indirect_i ? ar_rd : {page_q, offset_i};

  p_page_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_ld_i |=> page_q == $past(page_i));
endmodule

// File: tb/tb_agu_top.sv
module tb_agu_top;
  localparam time CLK = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        indirect, access, ptr_ld, page_ld, ar_wr;
  logic [6:0]  offset;
  logic [2:0]  mode, ptr, ar_wr_sel;
  logic [8:0]  page;
  logic [15:0] ar_wr_data, addr;
  logic [2:0]  ptr_q, prev_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK/2) clk = ~clk;

  agu_top dut (
    .clk_i(clk), .rst_ni(rst_n), .indirect_i(indirect), .access_i(access),
    .offset_i(offset), .mode_i(mode), .ptr_ld_i(ptr_ld), .ptr_i(ptr),
    .page_ld_i(page_ld), .page_i(page), .ar_wr_i(ar_wr),
    .ar_wr_sel_i(ar_wr_sel), .ar_wr_data_i(ar_wr_data),
    .addr_o(addr), .ptr_o(ptr_q), .prev_ptr_o(prev_q)
  );

  // {ptr_ld, ptr, mode, expected addr}; AR0=8 AR1=0 AR2=0x0100 AR3=0xFFFF, selector=1
  localparam logic [22:0] VEC [16] = '{
    {1'b0, 3'd0, 3'd5, 16'h0000},  // R6 walk
    {1'b0, 3'd0, 3'd5, 16'h0008},
    {1'b0, 3'd0, 3'd5, 16'h0004},
    {1'b0, 3'd0, 3'd5, 16'h000C},
    {1'b0, 3'd0, 3'd6, 16'h0002},  // R6 reverse borrow
    {1'b1, 3'd3, 3'd0, 16'h000C},  // R7 load with hold
    {1'b0, 3'd0, 3'd1, 16'hFFFF},  // R4 inc wrap
    {1'b0, 3'd0, 3'd2, 16'h0000},  // R4 dec wrap
    {1'b0, 3'd0, 3'd0, 16'hFFFF},
    {1'b1, 3'd2, 3'd3, 16'hFFFF},  // R5 add wrap, R7 old ptr stepped
    {1'b0, 3'd0, 3'd4, 16'h0100},  // R5 sub
    {1'b1, 3'd1, 3'd0, 16'h00F8},
    {1'b0, 3'd0, 3'd0, 16'h000C},
    {1'b1, 3'd3, 3'd3, 16'h000C},
    {1'b1, 3'd1, 3'd0, 16'h0007},
    {1'b0, 3'd0, 3'd0, 16'h0014}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    indirect = 1'b0; access = 1'b0; offset = '0; mode = '0;
    ptr_ld = 1'b0; ptr = '0; page_ld = 1'b0; page = '0;
    ar_wr = 1'b0; ar_wr_sel = '0; ar_wr_data = '0;
  endtask

  // drive after a falling edge; sample 1 ns later, before the committing rising edge
  task automatic drive(input logic ind, input logic acc, input logic [2:0] m,
                       input logic pl, input logic [2:0] p);
    @(negedge clk);
    idle();
    indirect = ind; access = acc; mode = m; ptr_ld = pl; ptr = p;
    #1;
  endtask

  task automatic write_ar(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    idle();
    ar_wr = 1'b1; ar_wr_sel = s; ar_wr_data = d;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle();
    #(CLK * 3);
    // R1 reset state
    check("R1 ptr", {13'd0, ptr_q}, 16'd0);
    check("R1 prev", {13'd0, prev_q}, 16'd0);
    check("R1 direct addr", addr, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    check("R1 AR0", addr, 16'h0000);

    write_ar(3'd0, 16'h0008);
    write_ar(3'd1, 16'h0000);
    write_ar(3'd2, 16'h0100);
    write_ar(3'd3, 16'hFFFF);
    drive(1'b0, 1'b0, 3'd0, 1'b1, 3'd1);

    for (int i = 0; i < 16; i++) begin
      drive(1'b1, 1'b1, VEC[i][18:16], VEC[i][22], VEC[i][21:19]);
      check($sformatf("R3-vec%0d", i), addr, VEC[i][15:0]);
    end
    drive(1'b0, 1'b0, 3'd0, 1'b0, 3'd0);
    check("R7 ptr after table", {13'd0, ptr_q}, 16'd1);
    check("R7 prev after table", {13'd0, prev_q}, 16'd3);

    // R6 borrow out of the MSB-side from zero
    write_ar(3'd4, 16'h0000);
    drive(1'b1, 1'b0, 3'd0, 1'b1, 3'd4);
    drive(1'b1, 1'b1, 3'd6, 1'b0, 3'd0);
    check("R6 rsub from 0 pre", addr, 16'h0000);
    drive(1'b1, 1'b1, 3'd7, 1'b0, 3'd0);
    check("R6 rsub from 0", addr, 16'h000F);
    drive(1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    check("R4 code 7 holds", addr, 16'h000F);
    check("R7 prev on load", {13'd0, prev_q}, 16'd1);

    // R8 write beats step on same register
    @(negedge clk);
    idle();
    indirect = 1'b1; access = 1'b1; mode = 3'd1;
    ar_wr = 1'b1; ar_wr_sel = 3'd4; ar_wr_data = 16'h1234;
    drive(1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    check("R8 write priority", addr, 16'h1234);
    check("R8 ptr held", {13'd0, ptr_q}, 16'd4);
    check("R8 prev held", {13'd0, prev_q}, 16'd1);

    // R9 / R2 direct addressing with a step code that must be ignored
    @(negedge clk);
    idle();
    page_ld = 1'b1; page = 9'h1A5;
    @(negedge clk);
    idle();
    access = 1'b1; mode = 3'd1; offset = 7'h7F;
    #1;
    check("R2 R9 direct addr", addr, 16'hD2FF);
    drive(1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    check("R2 AR untouched", addr, 16'h1234);

    done = 1'b1;
    finish_run();
  end
endmodule